// File: doc/BRIEF.md
# Per-VP Global Configuration Register Bank

This block is a small bank of memory-mapped configuration registers shared by a cluster of virtual processors (VPs). A single register sets the base address and the enable of the interrupt-controller window, and both drive output pins. A read-only status register tells software whether the interrupt controller is fitted. Every VP also owns two registers: a reset-base register that sets its exception base vector, and an "other" pointer that names a VP.

Each bus access carries the index of the calling VP as a sideband input. The per-VP registers are reached through two address sections. The local section addresses the caller's own registers. The other section addresses the registers of the VP that the caller's other pointer names, so one VP can set up another VP's boot vector before that VP is released. Each VP's exception base is taken from its reset-base register without delay. The 32-bit masked field is sign-extended to the output width.

Top module: `cmgcr_regs`

## Requirements
- R1: After reset, winBase and winEn are 0, rspValid is 0, every VP's other pointer reads 0, every reset-base register reads 0xBFC00000, and every excBase slice is 0xFFFFFFFF_BFC00000.
- R2: The window register sits at byte offset 0x008. Bits [31:16] hold the base and bit 0 holds the enable; all other bits read 0. The cycle after a write, winBase shows the stored base bits and winEn shows bit 0.
- R3: The status register sits at offset 0x010. Bit 0 reads the ctrlPresent input, the other bits read 0, and writes to it have no effect.
- R4: The local section starts at offset 0x100 and the other section at 0x200. Inside each section, 0x0 is core config, 0x4 is the other pointer and 0x8 is the reset base. Local accesses reach VP reqVp. Other accesses reach the VP named by reqVp's other pointer.
- R5: The reset-base field is bits [31:12]; the lower bits are dropped on write and read 0. The cycle after a reset-base write, that VP's excBase slice equals the stored value sign-extended from bit 31, and the other VPs' slices are unchanged.
- R6: A write to an other pointer with a value at or above NUM_VP leaves the pointer unchanged.
- R7: Core config reads NUM_VP-1 through either section.
- R8: Reads of unmapped offsets return 0, and writes to them change no register or output.
- R9: A read gives rspValid high for exactly one cycle, the cycle after the request, with rspData alongside. A write gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset in the bank |
| reqWdata | input | 32 | Write data |
| reqVp | input | VP_W | Index of the calling VP |
| ctrlPresent | input | 1 | Interrupt controller fitted |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Read data |
| winBase | output | 32 | Interrupt-controller window base |
| winEn | output | 1 | Interrupt-controller window enable |
| excBase | output | NUM_VP*EXC_W | Per-VP exception base, VP v in slice v |

## Verification
The assertions assume that a valid request always carries a caller index below NUM_VP. An index outside that range would select no pointer, and the target of an other-section access would be undefined. The bench drives only caller indices 0 to 3. It issues at most one access per cycle and never overlaps a read with the next request. It drives every pointer write value, legal or not, through reqWdata, so out-of-range pointers reach the register only as write data and never as a caller index.

// File: rtl/cmgcr_pkg.sv
package cmgcr_pkg;

  // Register offsets (byte addresses inside the bank)
  localparam int unsigned OFS_WIN     = 32'h008;
  localparam int unsigned OFS_STATUS  = 32'h010;
  localparam int unsigned SEC_LOCAL   = 32'h100;
  localparam int unsigned SEC_OTHER   = 32'h200;
  localparam int unsigned REG_CORECFG = 32'h0;
  localparam int unsigned REG_OTHER   = 32'h4;
  localparam int unsigned REG_RESET   = 32'h8;

  // Field masks and reset values
  localparam logic [31:0] WIN_MASK   = 32'hFFFF_0001;
  localparam logic [31:0] RESET_MASK = 32'hFFFF_F000;
  localparam logic [31:0] RESET_INIT = 32'hBFC0_0000;

  typedef enum logic [2:0] {
    SelZero,
    SelWin,
    SelStatus,
    SelCoreCfg,
    SelOther,
    SelResetBase
  } rdSel_e;

  typedef struct packed {
    logic   wrWin;
    logic   wrOther;
    logic   wrReset;
    logic   rdEn;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/cmgcr_ctrl.sv
module cmgcr_ctrl
  import cmgcr_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int VP_W   = 2,
  parameter int ADDR_W = 12
) (
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [VP_W-1:0]        reqVp,
  input  logic [NUM_VP*VP_W-1:0] otherPtrs,
  output strobe_t                strobe,
  output logic [VP_W-1:0]        targetVp
);

  logic [ADDR_W-1:0] secBase;
  logic [3:0]        regOfs;
  logic              inLocal;
  logic              inOther;
  logic [VP_W-1:0]   callerPtr;
  rdSel_e            sel;

  always_comb begin
    secBase   = {reqAddr[ADDR_W-1:4], 4'b0000};
    regOfs    = reqAddr[3:0];
    inLocal   = (secBase == ADDR_W'(SEC_LOCAL));
    inOther   = (secBase == ADDR_W'(SEC_OTHER));
    callerPtr = otherPtrs[int'(reqVp)*VP_W +: VP_W];
    targetVp  = inOther ? callerPtr : reqVp;

    sel = SelZero;
    if (reqAddr == ADDR_W'(OFS_WIN)) begin
      sel = SelWin;
    end else if (reqAddr == ADDR_W'(OFS_STATUS)) begin
      sel = SelStatus;
    end else if (inLocal || inOther) begin
      case (regOfs)
        4'(REG_CORECFG): sel = SelCoreCfg;
        4'(REG_OTHER):   sel = SelOther;
        4'(REG_RESET):   sel = SelResetBase;
        default:         sel = SelZero;
      endcase
    end

    strobe.rdSel   = sel;
    strobe.rdEn    = reqValid && !reqWrite;
    strobe.wrWin   = reqValid && reqWrite && (sel == SelWin);
    strobe.wrOther = reqValid && reqWrite && (sel == SelOther);
    strobe.wrReset = reqValid && reqWrite && (sel == SelResetBase);
  end

endmodule

// File: rtl/cmgcr_dpath.sv
module cmgcr_dpath
  import cmgcr_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int VP_W   = 2,
  parameter int EXC_W  = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [VP_W-1:0]         targetVp,
  input  logic [31:0]             wdata,
  input  logic                    ctrlPresent,
  output logic [NUM_VP*VP_W-1:0]  otherPtrs,
  output logic [31:0]             winBase,
  output logic                    winEn,
  output logic [NUM_VP*EXC_W-1:0] excBase,
  output logic                    rspValid,
  output logic [31:0]             rspData
);

  localparam int EXT_W = EXC_W - 32;

  logic [31:0]     winReg;
  logic [VP_W-1:0] otherArr [NUM_VP];
  logic [31:0]     resetArr [NUM_VP];
  logic [31:0]     rdNext;
  logic            ptrLegal;

  assign ptrLegal = (wdata < 32'(NUM_VP));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winReg <= '0;
    end else if (strobe.wrWin) begin
      winReg <= wdata & WIN_MASK;
    end
  end

  assign winBase = {winReg[31:16], 16'h0000};
  assign winEn   = winReg[0];

  for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
    logic [VP_W-1:0] otherReg;
    logic [31:0]     resetReg;
    logic            hit;

    assign hit = (targetVp == VP_W'(v));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        otherReg <= '0;
        resetReg <= RESET_INIT & RESET_MASK;
      end else begin
        if (strobe.wrOther && hit && ptrLegal) begin
          otherReg <= wdata[VP_W-1:0];
        end
        if (strobe.wrReset && hit) begin
          resetReg <= wdata & RESET_MASK;
        end
      end
    end

    assign otherArr[v] = otherReg;
    assign resetArr[v] = resetReg;
    assign otherPtrs[v*VP_W +: VP_W] = otherReg;
    assign excBase[v*EXC_W +: EXC_W] = {{EXT_W{resetReg[31]}}, resetReg};
  end

  always_comb begin
    case (strobe.rdSel)
      SelWin:       rdNext = winReg;
      SelStatus:    rdNext = {31'b0, ctrlPresent};
      SelCoreCfg:   rdNext = 32'(NUM_VP - 1);
      SelOther:     rdNext = 32'(otherArr[targetVp]);
      SelResetBase: rdNext = resetArr[targetVp];
      default:      rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.rdEn;
      rspData  <= strobe.rdEn ? rdNext : '0;
    end
  end

endmodule

// File: rtl/cmgcr_regs.sv
module cmgcr_regs
  import cmgcr_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int ADDR_W = 12,
  parameter int EXC_W  = 64,
  localparam int VP_W  = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [31:0]             reqWdata,
  input  logic [VP_W-1:0]         reqVp,
  input  logic                    ctrlPresent,
  output logic                    rspValid,
  output logic [31:0]             rspData,
  output logic [31:0]             winBase,
  output logic                    winEn,
  output logic [NUM_VP*EXC_W-1:0] excBase
);

  strobe_t                strobe;
  logic [VP_W-1:0]        targetVp;
  logic [NUM_VP*VP_W-1:0] otherPtrs;

  cmgcr_ctrl #(.NUM_VP(NUM_VP), .VP_W(VP_W), .ADDR_W(ADDR_W)) u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqVp    (reqVp),
    .otherPtrs(otherPtrs),
    .strobe   (strobe),
    .targetVp (targetVp)
  );

  cmgcr_dpath #(.NUM_VP(NUM_VP), .VP_W(VP_W), .EXC_W(EXC_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .targetVp   (targetVp),
    .wdata      (reqWdata),
    .ctrlPresent(ctrlPresent),
    .otherPtrs  (otherPtrs),
    .winBase    (winBase),
    .winEn      (winEn),
    .excBase    (excBase),
    .rspValid   (rspValid),
    .rspData    (rspData)
  );

endmodule

// File: rtl/cmgcr_regs_chk.sv
module cmgcr_regs_chk
  import cmgcr_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int ADDR_W = 12,
  parameter int EXC_W  = 64,
  parameter int VP_W   = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqValid,
  input logic                    reqWrite,
  input logic [ADDR_W-1:0]       reqAddr,
  input logic [31:0]             reqWdata,
  input logic [VP_W-1:0]         reqVp,
  input logic                    ctrlPresent,
  input logic                    rspValid,
  input logic [31:0]             rspData,
  input logic [31:0]             winBase,
  input logic                    winEn,
  input logic [NUM_VP*EXC_W-1:0] excBase
);

  logic anyWrite, anyRead, rdStatus, rdCoreCfg, wrWin;

  assign anyWrite  = reqValid && reqWrite;
  assign anyRead   = reqValid && !reqWrite;
  assign wrWin     = anyWrite && (reqAddr == ADDR_W'(OFS_WIN));
  assign rdStatus  = anyRead && (reqAddr == ADDR_W'(OFS_STATUS));
  assign rdCoreCfg = anyRead && ((reqAddr == ADDR_W'(SEC_LOCAL + REG_CORECFG)) ||
                                 (reqAddr == ADDR_W'(SEC_OTHER + REG_CORECFG)));

  AST_VP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (int'(reqVp) < NUM_VP)); // R4

  AST_WIN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrWin |=> (winBase == ($past(reqWdata) & 32'hFFFF_0000)) && (winEn == $past(reqWdata[0]))); // R2

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !anyWrite |=> $stable(winBase) && $stable(winEn)); // R2

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdStatus |=> (rspData == {31'b0, $past(ctrlPresent)})); // R3

  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !anyWrite |=> $stable(excBase)); // R5

  AST_CORECFG: assert property (@(posedge clk) disable iff (!rstN)
    rdCoreCfg |=> (rspData == 32'(NUM_VP - 1))); // R7

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    anyRead |=> rspValid); // R9

  AST_NO_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !anyRead |=> !rspValid); // R9

endmodule

bind cmgcr_regs cmgcr_regs_chk #(
  .NUM_VP(NUM_VP), .ADDR_W(ADDR_W), .EXC_W(EXC_W), .VP_W(VP_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqAddr    (reqAddr),
  .reqWdata   (reqWdata),
  .reqVp      (reqVp),
  .ctrlPresent(ctrlPresent),
  .rspValid   (rspValid),
  .rspData    (rspData),
  .winBase    (winBase),
  .winEn      (winEn),
  .excBase    (excBase)
);

// File: tb/cmgcr_regs_bench.sv
module cmgcr_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_VP     = 4;
  localparam int ADDR_W     = 12;
  localparam int EXC_W      = 64;
  localparam int VP_W       = 2;

  localparam logic [ADDR_W-1:0] A_WIN    = 12'h008;
  localparam logic [ADDR_W-1:0] A_STATUS = 12'h010;
  localparam logic [ADDR_W-1:0] A_L_CFG  = 12'h100;
  localparam logic [ADDR_W-1:0] A_L_OTH  = 12'h104;
  localparam logic [ADDR_W-1:0] A_L_RST  = 12'h108;
  localparam logic [ADDR_W-1:0] A_O_CFG  = 12'h200;
  localparam logic [ADDR_W-1:0] A_O_OTH  = 12'h204;
  localparam logic [ADDR_W-1:0] A_O_RST  = 12'h208;
  localparam logic [ADDR_W-1:0] A_UNMAP  = 12'h0FC;

  logic                    clk = 1'b0;
  logic                    rstN;
  logic                    reqValid;
  logic                    reqWrite;
  logic [ADDR_W-1:0]       reqAddr;
  logic [31:0]             reqWdata;
  logic [VP_W-1:0]         reqVp;
  logic                    ctrlPresent;
  logic                    rspValid;
  logic [31:0]             rspData;
  logic [31:0]             winBase;
  logic                    winEn;
  logic [NUM_VP*EXC_W-1:0] excBase;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmgcr_regs #(.NUM_VP(NUM_VP), .ADDR_W(ADDR_W), .EXC_W(EXC_W)) u_cmgcr_regs (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqVp(reqVp),
    .ctrlPresent(ctrlPresent), .rspValid(rspValid), .rspData(rspData),
    .winBase(winBase), .winEn(winEn), .excBase(excBase)
  );

  function automatic logic [63:0] sext(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] excOf(input int v);
    return excBase[v*EXC_W +: EXC_W];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d, input int vp);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d; reqVp = VP_W'(vp);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, input int vp, output logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqVp = VP_W'(vp);
    @(negedge clk);
    reqValid = 1'b0;
    d = rspData;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 winBase", 64'(winBase), 64'h0);
    check("R1 winEn", 64'(winEn), 64'h0);
    check("R1 rspValid", 64'(rspValid), 64'h0);
    for (int v = 0; v < NUM_VP; v++) check("R1 excBase", excOf(v), 64'hFFFF_FFFF_BFC0_0000);
    doRead(A_L_OTH, 1, d);
    check("R1 other ptr", 64'(d), 64'h0);
    doRead(A_L_RST, 2, d);
    check("R1 reset base", 64'(d), 64'hBFC0_0000);
  endtask

  task automatic t_window;
    logic [31:0] d;
    doWrite(A_WIN, 32'hABCD_1235, 0);
    check("R2 winBase", 64'(winBase), 64'hABCD_0000);
    check("R2 winEn", 64'(winEn), 64'h1);
    doRead(A_WIN, 3, d);
    check("R2 readback", 64'(d), 64'hABCD_0001);
    doWrite(A_WIN, 32'h1200_0000, 1);
    check("R2 winEn clear", 64'(winEn), 64'h0);
    check("R2 winBase new", 64'(winBase), 64'h1200_0000);
  endtask

  task automatic t_status;
    logic [31:0] d;
    ctrlPresent = 1'b1;
    doRead(A_STATUS, 0, d);
    check("R3 present", 64'(d), 64'h1);
    ctrlPresent = 1'b0;
    doRead(A_STATUS, 2, d);
    check("R3 absent", 64'(d), 64'h0);
    doWrite(A_STATUS, 32'hFFFF_FFFF, 0);
    doRead(A_STATUS, 0, d);
    check("R3 write ignored", 64'(d), 64'h0);
  endtask

  task automatic t_local_reset;
    logic [31:0] d;
    doWrite(A_L_RST, 32'h8000_0FFF, 2);
    check("R5 exc vp2 neg", excOf(2), 64'hFFFF_FFFF_8000_0000);
    check("R4 exc vp1 untouched", excOf(1), sext(32'hBFC0_0000));
    doRead(A_L_RST, 2, d);
    check("R5 masked read", 64'(d), 64'h8000_0000);
    doWrite(A_L_RST, 32'h1234_5678, 2);
    check("R5 exc vp2 pos", excOf(2), 64'h0000_0000_1234_5000);
  endtask

  task automatic t_other;
    logic [31:0] d;
    doWrite(A_L_OTH, 32'd3, 0);
    doRead(A_L_OTH, 0, d);
    check("R4 ptr set", 64'(d), 64'd3);
    doWrite(A_O_RST, 32'h7000_0000, 0);
    check("R4 other target exc", excOf(3), 64'h0000_0000_7000_0000);
    check("R4 caller exc untouched", excOf(0), sext(32'hBFC0_0000));
    doRead(A_O_RST, 0, d);
    check("R4 other readback", 64'(d), 64'h7000_0000);
    doRead(A_L_RST, 3, d);
    check("R4 local of vp3", 64'(d), 64'h7000_0000);
  endtask

  task automatic t_other_ignore;
    logic [31:0] d;
    doWrite(A_L_OTH, 32'd4, 0);
    doRead(A_L_OTH, 0, d);
    check("R6 ptr 4 ignored", 64'(d), 64'd3);
    doWrite(A_L_OTH, 32'hFFFF_FFFF, 0);
    doRead(A_L_OTH, 0, d);
    check("R6 ptr max ignored", 64'(d), 64'd3);
    doWrite(A_O_OTH, 32'd1, 0);
    doRead(A_L_OTH, 3, d);
    check("R4 other alias sets vp3 ptr", 64'(d), 64'd1);
  endtask

  task automatic t_corecfg;
    logic [31:0] d;
    doRead(A_O_CFG, 0, d);
    check("R7 other alias", 64'(d), 64'(NUM_VP - 1));
    doRead(A_L_CFG, 2, d);
    check("R7 local alias", 64'(d), 64'(NUM_VP - 1));
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    logic [NUM_VP*EXC_W-1:0] excSnap;
    excSnap = excBase;
    doRead(A_UNMAP, 0, d);
    check("R8 unmapped read", 64'(d), 64'h0);
    doWrite(A_UNMAP, 32'hDEAD_BEEF, 0);
    doWrite(12'h20C, 32'h5555_5555, 0);
    check("R8 winBase kept", 64'(winBase), 64'h1200_0000);
    check("R8 exc kept", 64'(excBase == excSnap), 64'h1);
    doRead(A_UNMAP, 1, d);
    check("R8 unmapped read again", 64'(d), 64'h0);
  endtask

  task automatic t_response;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = A_WIN; reqWdata = 32'h1200_0000; reqVp = '0;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    check("R9 no rsp on write", 64'(rspValid), 64'h0);
    reqValid = 1'b1; reqAddr = A_L_CFG;
    @(negedge clk);
    reqValid = 1'b0;
    check("R9 rsp valid", 64'(rspValid), 64'h1);
    @(negedge clk);
    check("R9 rsp one cycle", 64'(rspValid), 64'h0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0;
    reqWdata = '0; reqVp = '0; ctrlPresent = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_status();
    t_local_reset();
    t_other();
    t_other_ignore();
    t_corecfg();
    t_unmapped();
    t_response();
    summary();
  end

endmodule